// File: doc/BRIEF.md
# Bidirectional Mailbox Register Bank

The block passes short messages and semaphores between a host bus and local user logic. It holds two banks of eight byte-wide mailboxes. The outgoing bank is filled by local logic and drained by the host. The incoming bank is filled by the host and drained by local logic. Each byte carries a status bit that reads 1 while the byte holds data the other side has not yet consumed. The status bit is set by a write and cleared by the opposite side's read.

The host reaches the bank through a simple memory-mapped port. The port decodes a byte offset within a 256-byte window and carries 16-bit data, so that a configuration register fits in one access. Local logic uses a parallel port with one byte index. That port writes the outgoing bank and reads the incoming bank in the same cycle, and it also sees the whole incoming bank as one 64-bit word.

Each direction raises its own full and empty interrupts. An 8-bit mask selects which bytes take part, and two enable bits gate the interrupts. Both interrupts are level outputs, and software can dismiss either one with a write-one clear bit.

Top module: `mbox_bank`

## Requirements
- R1: A synchronous reset clears all mailbox data, both status registers and both configuration registers, and drops all four interrupts. After reset every host read returns 0 and `l_in_word` is 0.
- R2: A host write at offset 0x08+k stores the low data byte in incoming byte k and sets incoming status bit k. A local write with `l_idx`=k stores `l_wdata` in outgoing byte k and sets outgoing status bit k. Both changes take effect on the next clock edge. The host reads outgoing byte k at offset 0x00+k, and local logic reads incoming byte k on `l_rdata` in the same cycle.
- R3: A host read of offset 0x00+k clears outgoing status bit k on that clock edge, and a local read (`l_rd`, `l_idx`=k) clears incoming status bit k. A read by the side that wrote the byte (host read of 0x08+k) leaves the status unchanged.
- R4: `l_in_word` presents incoming byte k at bits 8k+7:8k, so byte 0 sits at bits 7:0 and byte 7 at bits 63:56.
- R5: Offset 0x10 reads the outgoing status and 0x11 the incoming status, with bit k for byte k. Offset 0x12 is the outgoing configuration and 0x13 the incoming configuration. Host writes to offsets 0x00-0x07, 0x10 and 0x11 are ignored. Offsets 0x14 and above read 0 and ignore writes.
- R6: Configuration format: bits 7:0 mask, bit 8 full enable, bit 9 empty enable, bit 10 full clear, bit 11 empty clear. The two clear bits act only on write and read back as 0, as do bits 15:12.
- R7: A full interrupt rises one clock after the status first shows every masked bit set, provided the full enable is 1 and the mask is nonzero.
- R8: An empty interrupt rises one clock after every masked status bit has returned to 0, provided at least one masked bit was set since the last empty event and the empty enable is 1.
- R9: Interrupts are levels. The full interrupt drops one clock after any masked bit clears, and the empty interrupt drops one clock after any masked bit is set.
- R10: Writing 1 to a clear bit drops the matching interrupt on that edge. The interrupt stays low while the same condition persists.
- R11: When the host writes an incoming byte in the same cycle that local logic reads it (and likewise for the outgoing direction), the write wins. The byte holds the new data and its status bit stays 1. The read returns the old data.
- R12: While `h_sel` is 0, the host port changes no data, status or configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_sel | input | 1 | Host access falls in the bank's 256-byte window |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 8 | Host byte offset in the window |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, same cycle, zero-extended for byte registers |
| l_wr | input | 1 | Local write of outgoing byte `l_idx` |
| l_rd | input | 1 | Local read (consume) of incoming byte `l_idx` |
| l_idx | input | 3 | Local byte index |
| l_wdata | input | 8 | Local write data |
| l_rdata | output | 8 | Incoming byte `l_idx` |
| l_in_word | output | 64 | Whole incoming bank |
| irq_out_full | output | 1 | Outgoing full interrupt |
| irq_out_empty | output | 1 | Outgoing empty interrupt |
| irq_in_full | output | 1 | Incoming full interrupt |
| irq_in_empty | output | 1 | Incoming empty interrupt |

## Verification
A producer write and a consumer read can land on the same byte in the same cycle. The bench provokes this by driving a host write to 0x08 together with a local read of index 0. It then judges the result in three ways: the read must return the old byte in that cycle, the incoming status must still show the bit set afterwards, and a later local read must return the new byte. A write-one clear can also coincide with a condition that is still true. That case is judged by checking that the interrupt stays low on the following clocks.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;

    localparam int NBYTE = 8;
    localparam int BW    = 8;
    localparam int HDW   = 16;
    localparam int AW    = 8;
    localparam int IW    = $clog2(NBYTE);
    localparam int WORDW = NBYTE * BW;

    localparam logic [AW-1:0] OFF_OUT  = 8'h00;
    localparam logic [AW-1:0] OFF_IN   = 8'h08;
    localparam logic [AW-1:0] OFF_OST  = 8'h10;
    localparam logic [AW-1:0] OFF_IST  = 8'h11;
    localparam logic [AW-1:0] OFF_OCFG = 8'h12;
    localparam logic [AW-1:0] OFF_ICFG = 8'h13;

    // Interrupt configuration word
    typedef struct packed {
        logic [3:0]       rsvd;
        logic             clr_empty;
        logic             clr_full;
        logic             en_empty;
        logic             en_full;
        logic [NBYTE-1:0] mask;
    } cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_OUT, SEL_IN, SEL_OST, SEL_IST, SEL_OCFG, SEL_ICFG
    } hsel_e;

    function automatic hsel_e decode_off(input logic [AW-1:0] a);
        hsel_e s;
        if (a < OFF_IN)       s = SEL_OUT;
        else if (a < OFF_OST) s = SEL_IN;
        else begin
            case (a)
                OFF_OST:  s = SEL_OST;
                OFF_IST:  s = SEL_IST;
                OFF_OCFG: s = SEL_OCFG;
                OFF_ICFG: s = SEL_ICFG;
                default:  s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    // Keep only the stored fields of a written configuration
    function automatic cfg_t cfg_store(input cfg_t w);
        cfg_t c;
        c           = '0;
        c.mask      = w.mask;
        c.en_full   = w.en_full;
        c.en_empty  = w.en_empty;
        return c;
    endfunction

endpackage

// File: rtl/mbox_dir.sv
`timescale 1ns/1ps
module mbox_dir
    import mbox_pkg::*;
#(
    parameter int N  = NBYTE,
    parameter int W  = BW,
    localparam int XW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [XW-1:0]  wr_idx,
    input  logic [W-1:0]   wr_data,
    input  logic           clr_en,
    input  logic [XW-1:0]  clr_idx,
    output logic [N*W-1:0] word,
    output logic [N-1:0]   status
);

    logic [W-1:0] bytes [N];

    for (genvar b = 0; b < N; b++) begin : g_byte
        logic         hit_w;
        logic         hit_c;
        logic [W-1:0] d_q;
        logic         s_q;

        assign hit_w = wr_en  && (wr_idx  == XW'(b));
        assign hit_c = clr_en && (clr_idx == XW'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                d_q <= '0;
                s_q <= 1'b0;
            end else if (hit_w) begin
                d_q <= wr_data;   // write wins over a same-cycle read
                s_q <= 1'b1;
            end else if (hit_c) begin
                s_q <= 1'b0;
            end
        end

        assign bytes[b]         = d_q;
        assign word[b*W +: W]   = d_q;
        assign status[b]        = s_q;
    end

    a_r2_write_sets: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> status[$past(wr_idx)] && (bytes[$past(wr_idx)] == $past(wr_data)));

    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(wr_en && wr_idx == clr_idx)) |=> !status[$past(clr_idx)]);

    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        (clr_en && wr_en && wr_idx == clr_idx) |=> status[$past(clr_idx)]);

endmodule

// File: rtl/mbox_irq.sv
`timescale 1ns/1ps
module mbox_irq
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [HDW-1:0]   cfg_wdata,
    input  logic [NBYTE-1:0] status,
    output logic [HDW-1:0]   cfg_rd,
    output logic             irq_full,
    output logic             irq_empty
);

    cfg_t             cfg_q;
    cfg_t             wcfg;
    logic [NBYTE-1:0] masked;
    logic             full_cond;
    logic             full_prev;
    logic             any_set;
    logic             armed;

    assign wcfg      = cfg_t'(cfg_wdata);
    assign masked    = status & cfg_q.mask;
    assign any_set   = |masked;
    assign full_cond = cfg_q.en_full && (cfg_q.mask != '0) && (masked == cfg_q.mask);
    assign cfg_rd    = HDW'(cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            full_prev <= 1'b0;
            armed     <= 1'b0;
            irq_full  <= 1'b0;
            irq_empty <= 1'b0;
        end else begin
            full_prev <= full_cond;
            if (cfg_we) cfg_q <= cfg_store(wcfg);

            if (!full_cond)                   irq_full <= 1'b0;
            else if (cfg_we && wcfg.clr_full) irq_full <= 1'b0;
            else if (!full_prev)              irq_full <= 1'b1;

            if (any_set)    armed <= 1'b1;
            else if (armed) armed <= 1'b0;

            if (any_set || !cfg_q.en_empty)    irq_empty <= 1'b0;
            else if (cfg_we && wcfg.clr_empty) irq_empty <= 1'b0;
            else if (armed)                    irq_empty <= 1'b1;
        end
    end

    a_r9_full_drops: assert property (@(posedge clk) disable iff (rst)
        ((status & cfg_q.mask) != cfg_q.mask) |=> !irq_full);

    a_r9_empty_drops: assert property (@(posedge clk) disable iff (rst)
        ((status & cfg_q.mask) != '0) |=> !irq_empty);

    a_r10_full_clear: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[10]) |=> !irq_full);

    a_r10_empty_clear: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[11]) |=> !irq_empty);

    a_r6_clear_bits_unstored: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_rd[HDW-1:10] == '0));

endmodule

// File: rtl/mbox_host_if.sv
`timescale 1ns/1ps
module mbox_host_if
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             h_sel,
    input  logic             h_wr,
    input  logic             h_rd,
    input  logic [AW-1:0]    h_addr,
    input  logic [HDW-1:0]   h_wdata,
    output logic [HDW-1:0]   h_rdata,
    input  logic [WORDW-1:0] out_word,
    input  logic [WORDW-1:0] in_word,
    input  logic [NBYTE-1:0] out_status,
    input  logic [NBYTE-1:0] in_status,
    input  logic [HDW-1:0]   ocfg,
    input  logic [HDW-1:0]   icfg,
    output logic             in_wr_en,
    output logic [IW-1:0]    in_wr_idx,
    output logic [BW-1:0]    in_wr_data,
    output logic             out_clr_en,
    output logic [IW-1:0]    out_clr_idx,
    output logic             ocfg_we,
    output logic             icfg_we
);

    hsel_e        sel;
    logic [IW-1:0] idx;
    logic          wr_q;
    logic          rd_q;

    assign sel  = decode_off(h_addr);
    assign idx  = h_addr[IW-1:0];
    assign wr_q = h_sel && h_wr;
    assign rd_q = h_sel && h_rd;

    assign in_wr_en    = wr_q && (sel == SEL_IN);
    assign in_wr_idx   = idx;
    assign in_wr_data  = h_wdata[BW-1:0];
    assign out_clr_en  = rd_q && (sel == SEL_OUT);
    assign out_clr_idx = idx;
    assign ocfg_we     = wr_q && (sel == SEL_OCFG);
    assign icfg_we     = wr_q && (sel == SEL_ICFG);

    always_comb begin
        h_rdata = '0;
        if (rd_q) begin
            case (sel)
                SEL_OUT:  h_rdata = HDW'(out_word[idx*BW +: BW]);
                SEL_IN:   h_rdata = HDW'(in_word[idx*BW +: BW]);
                SEL_OST:  h_rdata = HDW'(out_status);
                SEL_IST:  h_rdata = HDW'(in_status);
                SEL_OCFG: h_rdata = ocfg;
                SEL_ICFG: h_rdata = icfg;
                default:  h_rdata = '0;
            endcase
        end
    end

    a_r5_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (h_sel && h_rd && h_addr > OFF_ICFG) |-> (h_rdata == '0));

    a_r12_idle_port: assert property (@(posedge clk) disable iff (rst)
        !h_sel |-> !(in_wr_en || out_clr_en || ocfg_we || icfg_we));

endmodule

// File: rtl/mbox_bank.sv
`timescale 1ns/1ps
module mbox_bank
    import mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        h_sel,
    input  logic        h_wr,
    input  logic        h_rd,
    input  logic [7:0]  h_addr,
    input  logic [15:0] h_wdata,
    output logic [15:0] h_rdata,
    input  logic        l_wr,
    input  logic        l_rd,
    input  logic [2:0]  l_idx,
    input  logic [7:0]  l_wdata,
    output logic [7:0]  l_rdata,
    output logic [63:0] l_in_word,
    output logic        irq_out_full,
    output logic        irq_out_empty,
    output logic        irq_in_full,
    output logic        irq_in_empty
);

    logic [WORDW-1:0] out_word;
    logic [WORDW-1:0] in_word;
    logic [NBYTE-1:0] out_status;
    logic [NBYTE-1:0] in_status;
    logic [HDW-1:0]   ocfg;
    logic [HDW-1:0]   icfg;
    logic             in_wr_en;
    logic [IW-1:0]    in_wr_idx;
    logic [BW-1:0]    in_wr_data;
    logic             out_clr_en;
    logic [IW-1:0]    out_clr_idx;
    logic             ocfg_we;
    logic             icfg_we;

    mbox_host_if u_host (
        .clk, .rst, .h_sel, .h_wr, .h_rd, .h_addr, .h_wdata, .h_rdata,
        .out_word, .in_word, .out_status, .in_status, .ocfg, .icfg,
        .in_wr_en, .in_wr_idx, .in_wr_data, .out_clr_en, .out_clr_idx,
        .ocfg_we, .icfg_we
    );

    // Local -> host
    mbox_dir #(.N(NBYTE), .W(BW)) u_out (
        .clk, .rst,
        .wr_en(l_wr), .wr_idx(l_idx), .wr_data(l_wdata),
        .clr_en(out_clr_en), .clr_idx(out_clr_idx),
        .word(out_word), .status(out_status)
    );

    // Host -> local
    mbox_dir #(.N(NBYTE), .W(BW)) u_in (
        .clk, .rst,
        .wr_en(in_wr_en), .wr_idx(in_wr_idx), .wr_data(in_wr_data),
        .clr_en(l_rd), .clr_idx(l_idx),
        .word(in_word), .status(in_status)
    );

    mbox_irq u_out_irq (
        .clk, .rst, .cfg_we(ocfg_we), .cfg_wdata(h_wdata), .status(out_status),
        .cfg_rd(ocfg), .irq_full(irq_out_full), .irq_empty(irq_out_empty)
    );

    mbox_irq u_in_irq (
        .clk, .rst, .cfg_we(icfg_we), .cfg_wdata(h_wdata), .status(in_status),
        .cfg_rd(icfg), .irq_full(irq_in_full), .irq_empty(irq_in_empty)
    );

    assign l_rdata   = in_word[l_idx*BW +: BW];
    assign l_in_word = in_word;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (out_status == '0 && in_status == '0 && in_word == '0 &&
                 !irq_out_full && !irq_out_empty && !irq_in_full && !irq_in_empty));

endmodule

// File: tb/mbox_bank_bench.sv
`timescale 1ns/1ps
module mbox_bank_bench;

    typedef enum logic [2:0] {OP_HW, OP_HR, OP_LW, OP_LR, OP_IRQ, OP_COL, OP_HWN} op_e;

    typedef struct packed {
        op_e         op;
        logic [7:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    // irq vector order for OP_IRQ: {in_empty, in_full, out_empty, out_full}
    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{OP_HW,  8'h08, 16'h00A5, 16'h0000, 8'd2},   // R2 incoming byte 0
        '{OP_HW,  8'h0F, 16'h003C, 16'h0000, 8'd2},   // R2 incoming byte 7
        '{OP_HR,  8'h11, 16'h0000, 16'h0081, 8'd2},   // R2 status bits 0 and 7
        '{OP_HR,  8'h08, 16'h0000, 16'h00A5, 8'd3},   // R3 host readback of own byte
        '{OP_HR,  8'h11, 16'h0000, 16'h0081, 8'd3},   // R3 same-side read keeps status
        '{OP_LR,  8'h07, 16'h0000, 16'h003C, 8'd2},   // R2 local read of byte 7
        '{OP_HR,  8'h11, 16'h0000, 16'h0001, 8'd3},   // R3 local read cleared bit 7
        '{OP_LW,  8'h02, 16'h005A, 16'h0000, 8'd2},   // R2 outgoing byte 2
        '{OP_HR,  8'h10, 16'h0000, 16'h0004, 8'd2},   // R2 outgoing status
        '{OP_HR,  8'h02, 16'h0000, 16'h005A, 8'd2},   // R2 host reads outgoing byte
        '{OP_HR,  8'h10, 16'h0000, 16'h0000, 8'd3},   // R3 host read cleared it
        '{OP_HW,  8'h00, 16'h0077, 16'h0000, 8'd5},   // R5 host write to outgoing ignored
        '{OP_HR,  8'h00, 16'h0000, 16'h0000, 8'd5},   // R5
        '{OP_HR,  8'h10, 16'h0000, 16'h0000, 8'd5},   // R5
        '{OP_HW,  8'h20, 16'h00FF, 16'h0000, 8'd5},   // R5 unmapped write
        '{OP_HR,  8'h20, 16'h0000, 16'h0000, 8'd5},   // R5 unmapped read
        '{OP_HW,  8'h11, 16'h00FF, 16'h0000, 8'd5},   // R5 status is read-only
        '{OP_HR,  8'h11, 16'h0000, 16'h0001, 8'd5},   // R5
        '{OP_HW,  8'h13, 16'h0303, 16'h0000, 8'd6},   // R6 in cfg mask 03, both enables
        '{OP_HR,  8'h13, 16'h0000, 16'h0303, 8'd6},   // R6 readback
        '{OP_HW,  8'h12, 16'hFD01, 16'h0000, 8'd6},   // R6 clear/reserved bits not stored
        '{OP_HR,  8'h12, 16'h0000, 16'h0101, 8'd6},   // R6
        '{OP_HW,  8'h09, 16'h0011, 16'h0000, 8'd7},   // R7 fills masked bytes
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0004, 8'd7},   // R7 in full
        '{OP_HW,  8'h13, 16'h0703, 16'h0000, 8'd10},  // R10 clear in full
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0000, 8'd10},  // R10 stays low
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0000, 8'd10},  // R10 still low
        '{OP_LR,  8'h00, 16'h0000, 16'h00A5, 8'd8},   // R8 one masked byte left
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0000, 8'd8},   // R8 not empty yet
        '{OP_LR,  8'h01, 16'h0000, 16'h0011, 8'd8},   // R8
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0008, 8'd8},   // R8 in empty
        '{OP_HW,  8'h08, 16'h0022, 16'h0000, 8'd9},   // R9
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0000, 8'd9},   // R9 empty dropped
        '{OP_HW,  8'h09, 16'h0033, 16'h0000, 8'd9},   // R9
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0004, 8'd9},   // R9 full again
        '{OP_LR,  8'h01, 16'h0000, 16'h0033, 8'd9},   // R9
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0000, 8'd9},   // R9 full dropped
        '{OP_COL, 8'h08, 16'h0044, 16'h0022, 8'd11},  // R11 collision returns old data
        '{OP_HR,  8'h11, 16'h0000, 16'h0001, 8'd11}   // R11 status stays set
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_sel = 1'b0, h_wr = 1'b0, h_rd = 1'b0;
    logic [7:0]  h_addr = '0;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic        l_wr = 1'b0, l_rd = 1'b0;
    logic [2:0]  l_idx = '0;
    logic [7:0]  l_wdata = '0;
    logic [7:0]  l_rdata;
    logic [63:0] l_in_word;
    logic        irq_out_full, irq_out_empty, irq_in_full, irq_in_empty;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mbox_bank u_mbox_bank (
        .clk, .rst, .h_sel, .h_wr, .h_rd, .h_addr, .h_wdata, .h_rdata,
        .l_wr, .l_rd, .l_idx, .l_wdata, .l_rdata, .l_in_word,
        .irq_out_full, .irq_out_empty, .irq_in_full, .irq_in_empty
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        h_sel = 0; h_wr = 0; h_rd = 0; l_wr = 0; l_rd = 0;
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d op=%0d addr=%h", v.req, v.op, v.addr);
        if (v.op == OP_IRQ) begin
            @(posedge clk); #1;
            check(tag, 64'({irq_in_empty, irq_in_full, irq_out_empty, irq_out_full}), 64'(v.exp));
            return;
        end
        @(negedge clk);
        case (v.op)
            OP_HW:  begin h_sel = 1; h_wr = 1; h_addr = v.addr; h_wdata = v.data; end
            OP_HWN: begin h_sel = 0; h_wr = 1; h_addr = v.addr; h_wdata = v.data; end
            OP_HR:  begin h_sel = 1; h_rd = 1; h_addr = v.addr; end
            OP_LW:  begin l_wr = 1; l_idx = v.addr[2:0]; l_wdata = v.data[7:0]; end
            OP_LR:  begin l_rd = 1; l_idx = v.addr[2:0]; end
            OP_COL: begin h_sel = 1; h_wr = 1; h_addr = v.addr; h_wdata = v.data;
                          l_rd = 1; l_idx = v.addr[2:0]; end
            default: ;
        endcase
        #2;
        if (v.op == OP_HR) check(tag, 64'(h_rdata), 64'(v.exp));
        if (v.op == OP_LR || v.op == OP_COL) check(tag, 64'(l_rdata), 64'(v.exp));
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic hr(input logic [7:0] a, input logic [15:0] e, input string tag);
        run_vec('{OP_HR, a, 16'h0, e, 8'd0});
        if (h_rdata === 16'hxxxx) $display("%s", tag);
    endtask

    task automatic reset_checks(input string tag);
        check({tag, " irqs"}, 64'({irq_in_empty, irq_in_full, irq_out_empty, irq_out_full}), 64'h0);
        check({tag, " l_in_word"}, l_in_word, 64'h0);
        foreach (VEC[i]) begin end
        for (int a = 8'h08; a <= 8'h13; a += 3) begin
            @(negedge clk); h_sel = 1; h_rd = 1; h_addr = 8'(a); #2;
            check($sformatf("%s read %h", tag, a), 64'(h_rdata), 64'h0);
            @(posedge clk); #1; idle_inputs();
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 0;
        reset_checks("R1 initial");

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R11: the colliding write holds the new byte
        run_vec('{OP_LR, 8'h00, 16'h0, 16'h0044, 8'd11});
        run_vec('{OP_HW, 8'h13, 16'h0B03, 16'h0, 8'd10});
        run_vec('{OP_IRQ, 8'h00, 16'h0, 16'h0000, 8'd10});       // R10 empty clear

        // R7/R8 on the outgoing direction
        run_vec('{OP_HW, 8'h12, 16'h0301, 16'h0, 8'd7});
        run_vec('{OP_LW, 8'h00, 16'h0099, 16'h0, 8'd7});
        run_vec('{OP_IRQ, 8'h00, 16'h0, 16'h0001, 8'd7});        // R7 out full
        run_vec('{OP_HR, 8'h00, 16'h0, 16'h0099, 8'd3});
        run_vec('{OP_IRQ, 8'h00, 16'h0, 16'h0002, 8'd8});        // R8 out empty

        // R12: deselected host write changes nothing
        run_vec('{OP_HWN, 8'h08, 16'h0055, 16'h0, 8'd12});
        run_vec('{OP_HR, 8'h11, 16'h0, 16'h0000, 8'd12});
        run_vec('{OP_HR, 8'h08, 16'h0, 16'h0044, 8'd12});
        run_vec('{OP_HWN, 8'h13, 16'h0000, 16'h0, 8'd12});
        run_vec('{OP_HR, 8'h13, 16'h0, 16'h0303, 8'd12});

        // R4: byte packing of the incoming word
        #1 check("R4 l_in_word packing", l_in_word, 64'h3C00_0000_0000_3344);

        // R1: reset mid-run
        @(negedge clk); rst = 1;
        @(posedge clk); #1 rst = 0;
        reset_checks("R1 mid-run");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule